// File: doc/BRIEF.md
# Return Address Guard with Hidden Stack

This block protects subroutine returns. On each guarded call it takes the return address, reduces it to 52 bits, mixes it with a secret key that is loaded once after reset, and folds the mix into a 12-bit tag. It then hands back a 64-bit link value that carries the tag in its upper bits and the address in its lower bits. The same call also saves the 52-bit return address on a private last-in, first-out stack that software cannot reach.

Control-flow events arrive on a valid/ready stream, one event per transfer. The kind of each event comes from a marker already decoded at the jump target. A return-marked jump removes the newest stack entry and compares it with the jump address, including the tag. A call whose target is a base-register set-up entry is tagged but not saved. A plain jump leaves the stack as it is. The result of each event comes out on a second valid/ready stream. Back-pressure works as follows: the input is ready only when the output register is empty or is being taken in the same cycle. While the output is held, the result stays stable and the stack does not change.

Top module: `ret_guard`

## Requirements
- R1: With guarding on, a call (kind 2'b01) returns link = {T, A[51:0]} one cycle after acceptance. Here T is the 12-bit fold of K xor {12'b0, A[51:0]}: T bit i is the XOR of every bit i+12j of that 64-bit word. K is the key register. The violation flag is 0.
- R2: With guarding off, any event returns link equal to the input address, the flag is 0, and the stack is left unchanged.
- R3: With guarding on, a return-marked jump (kind 2'b10) removes the newest entry. The flag is 1 when the entry differs from the jump address bits 51:0, and 0 when it matches and the tag is right.
- R4: With guarding on, a return-marked jump whose address bits 63:52 differ from the tag recomputed from its bits 51:0 raises the flag.
- R5: A return-marked jump to an empty stack raises the flag.
- R6: The stack holds 16 entries. A call to a full stack discards the oldest entry, and entries come back newest first.
- R7: A call to a base set-up target (kind 2'b11) returns the tagged link value but saves nothing.
- R8: A plain jump (kind 2'b00) returns link equal to the input address, the flag is 0, and the stack is unchanged.
- R9: Only the first key load after reset takes effect. An event accepted in the same cycle as that load uses the key value from before the load, which is zero after reset.
- R10: While res_valid is high and res_ready is low, ev_ready is low, and res_link and res_viol hold steady.
- R11: After reset, res_valid is 0, ev_ready is 1, the key is zero and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| guard_en | input | 1 | Guarding enable |
| key_load | input | 1 | Key load strobe (first one only) |
| key_value | input | 64 | Random key value |
| ev_valid | input | 1 | Event valid |
| ev_ready | output | 1 | Event ready |
| ev_kind | input | 2 | 00 jump, 01 call, 10 return jump, 11 base set-up call |
| ev_addr | input | 64 | Return address (calls) or jump address (jumps) |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result ready |
| res_link | output | 64 | Link value or passed-through address |
| res_viol | output | 1 | Return check violation |

## Verification
Two kinds of same-cycle overlap are tested. In the first, the one-time key load is driven in the same cycle as an accepted call. The returned tag must use the zero key, and the next call must use the loaded key. In the second, the output register is released in the same cycle that a stalled call is accepted. This must produce exactly one new result and exactly one stack entry. That is confirmed by popping both saved addresses cleanly and then finding an underflow.

// File: rtl/ret_guard_pkg.sv
package ret_guard_pkg;
  localparam int LINK_W = 64;
  localparam int ADDR_W = 52;
  localparam int TAG_W  = LINK_W - ADDR_W;

  typedef enum logic [1:0] {
    EV_JUMP      = 2'b00,
    EV_CALL      = 2'b01,
    EV_RETURN    = 2'b10,
    EV_CALL_BASE = 2'b11
  } ev_kind_t;
endpackage

// File: rtl/rg_tag_fold.sv
module rg_tag_fold #(
  parameter int IN_W  = 64,
  parameter int OUT_W = 12
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] tag
);
  localparam int NCHUNK = (IN_W + OUT_W - 1) / OUT_W;
  localparam int PAD_W  = NCHUNK * OUT_W;

  logic [PAD_W-1:0] padded;
  logic [OUT_W-1:0] part [NCHUNK];

  assign padded = {{(PAD_W-IN_W){1'b0}}, din};

  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    assign part[c] = padded[c*OUT_W +: OUT_W];
  end

  always_comb begin
    tag = '0;
    for (int c = 0; c < NCHUNK; c++) tag = tag ^ part[c];
  end
endmodule

// File: rtl/rg_hidden_stack.sv
module rg_hidden_stack #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] top_data,
  output logic              empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  prev_ptr;
  logic [PTR_W-1:0]  next_ptr;

  assign prev_ptr = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
  assign next_ptr = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  assign top_data = mem[prev_ptr];
  assign empty    = (count == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      count  <= '0;
    end else if (push) begin
      wr_ptr <= next_ptr;
      if (count != FULL) count <= count + 1'b1;
    end else if (pop && !empty) begin
      wr_ptr <= prev_ptr;
      count  <= count - 1'b1;
    end
  end
endmodule

// File: rtl/ret_guard.sv
module ret_guard
  import ret_guard_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              guard_en,
  input  logic              key_load,
  input  logic [LINK_W-1:0] key_value,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [1:0]        ev_kind,
  input  logic [LINK_W-1:0] ev_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [LINK_W-1:0] res_link,
  output logic              res_viol
);
  localparam int CNT_W = $clog2(DEPTH+1);

  ev_kind_t          kind;
  logic [LINK_W-1:0] key_q;
  logic              key_done;
  logic              accept;
  logic [ADDR_W-1:0] addr_lo;
  logic [TAG_W-1:0]  addr_hi;
  logic [TAG_W-1:0]  calc_tag;
  logic              is_call;
  logic              do_push;
  logic              do_pop;
  logic [ADDR_W-1:0] stk_top;
  logic              stk_empty;
  logic [CNT_W-1:0]  stk_count;
  logic [LINK_W-1:0] link_next;
  logic              viol_next;

  assign kind    = ev_kind_t'(ev_kind);
  assign addr_lo = ev_addr[ADDR_W-1:0];
  assign addr_hi = ev_addr[LINK_W-1:ADDR_W];

  // one-shot key register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q    <= '0;
      key_done <= 1'b0;
    end else if (key_load && !key_done) begin
      key_q    <= key_value;
      key_done <= 1'b1;
    end
  end

  rg_tag_fold #(.IN_W(LINK_W), .OUT_W(TAG_W)) u_fold (
    .din (key_q ^ {{TAG_W{1'b0}}, addr_lo}),
    .tag (calc_tag)
  );

  assign ev_ready = !res_valid || res_ready;
  assign accept   = ev_valid && ev_ready;
  assign is_call  = (kind == EV_CALL) || (kind == EV_CALL_BASE);
  assign do_push  = accept && guard_en && (kind == EV_CALL);
  assign do_pop   = accept && guard_en && (kind == EV_RETURN);

  rg_hidden_stack #(.DEPTH(DEPTH), .DATA_W(ADDR_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (do_push),
    .pop       (do_pop),
    .push_data (addr_lo),
    .top_data  (stk_top),
    .empty     (stk_empty),
    .count     (stk_count)
  );

  always_comb begin
    link_next = ev_addr;
    viol_next = 1'b0;
    if (guard_en) begin
      if (is_call) link_next = {calc_tag, addr_lo};
      if (kind == EV_RETURN)
        viol_next = stk_empty || (stk_top != addr_lo) || (addr_hi != calc_tag);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_link  <= '0;
      res_viol  <= 1'b0;
    end else if (ev_ready) begin
      res_valid <= ev_valid;
      if (ev_valid) begin
        res_link <= link_next;
        res_viol <= viol_next;
      end
    end
  end
endmodule

// File: rtl/ret_guard_checks.sv
module ret_guard_checks #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        guard_en,
  input logic        ev_valid,
  input logic        ev_ready,
  input logic [1:0]  ev_kind,
  input logic [63:0] ev_addr,
  input logic        res_valid,
  input logic        res_ready,
  input logic [63:0] res_link,
  input logic        res_viol,
  input logic [$clog2(DEPTH+1)-1:0] stk_count
);
  logic acc;
  assign acc = ev_valid && ev_ready;

  assert_stall_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !ev_ready);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_link) && $stable(res_viol)));

  assert_off_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !guard_en) |=> (!res_viol && res_link == $past(ev_addr)));

  assert_jump_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ev_kind == 2'b00) |=> (!res_viol && res_link == $past(ev_addr)));

  assert_call_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && guard_en && ev_kind[0]) |=> (!res_viol && res_link[51:0] == $past(ev_addr[51:0])));

  assert_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && guard_en && ev_kind == 2'b10 && stk_count == '0) |=> res_viol);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stk_count <= ($clog2(DEPTH+1))'(DEPTH));

  assert_base_nopush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ev_kind == 2'b11) |=> $stable(stk_count));
endmodule

bind ret_guard ret_guard_checks #(.DEPTH(DEPTH)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .guard_en  (guard_en),
  .ev_valid  (ev_valid),
  .ev_ready  (ev_ready),
  .ev_kind   (ev_kind),
  .ev_addr   (ev_addr),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_link  (res_link),
  .res_viol  (res_viol),
  .stk_count (stk_count)
);

// File: tb/ret_guard_test.sv
module ret_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        guard_en = 1'b1;
  logic        key_load = 1'b0;
  logic [63:0] key_value = '0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [1:0]  ev_kind = 2'b00;
  logic [63:0] ev_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [63:0] res_link;
  logic        res_viol;

  int checks = 0;
  int fails  = 0;

  localparam logic [63:0] K1 = 64'hA5C3_19F0_7E2D_4B86;
  localparam logic [63:0] K2 = 64'h0123_4567_89AB_CDEF;

  always #4 clk = ~clk;

  ret_guard uut (
    .clk(clk), .rst_n(rst_n), .guard_en(guard_en),
    .key_load(key_load), .key_value(key_value),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind), .ev_addr(ev_addr),
    .res_valid(res_valid), .res_ready(res_ready), .res_link(res_link), .res_viol(res_viol)
  );

  function automatic logic [11:0] fold_tag(input logic [63:0] key, input logic [51:0] a);
    logic [63:0] x;
    logic [11:0] t;
    x = key ^ {12'b0, a};
    t = '0;
    for (int i = 0; i < 12; i++)
      for (int b = i; b < 64; b += 12) t[i] = t[i] ^ x[b];
    return t;
  endfunction

  function automatic logic [63:0] link_of(input logic [63:0] key, input logic [51:0] a);
    return {fold_tag(key, a), a};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ev_valid = 1'b0; key_load = 1'b0; res_ready = 1'b1; guard_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load_key(input logic [63:0] k);
    @(negedge clk);
    key_load = 1'b1; key_value = k;
    @(negedge clk);
    key_load = 1'b0;
  endtask

  task automatic issue(input logic [1:0] k, input logic [63:0] a);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_addr = a;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 res_valid", {63'b0, res_valid}, 64'd0);
    chk("R11 ev_ready", {63'b0, ev_ready}, 64'd1);
    issue(2'b01, 64'h0000_0000_0000_1000);
    chk("R11 zero key", res_link, link_of(64'd0, 52'h1000));
    issue(2'b10, link_of(64'd0, 52'h1000));
    chk("R11 pop ok", {63'b0, res_viol}, 64'd0);
    issue(2'b10, link_of(64'd0, 52'h1000));
    chk("R11 empty stack", {63'b0, res_viol}, 64'd1);
  endtask

  task automatic t_call_tag();
    do_reset(); load_key(K1);
    issue(2'b01, 64'hFFF0_0000_0000_0004);
    chk("R1 call a", res_link, link_of(K1, 52'h0000_0000_0004));
    chk("R1 valid", {63'b0, res_valid}, 64'd1);
    issue(2'b01, 64'h000F_FFFF_FFFF_FFFC);
    chk("R1 call b", res_link, link_of(K1, 52'hF_FFFF_FFFF_FFFC));
    issue(2'b01, 64'h0001_2345_6789_ABC0);
    chk("R1 call c", res_link, link_of(K1, 52'h1_2345_6789_ABC0));
  endtask

  task automatic t_return_match();
    do_reset(); load_key(K1);
    issue(2'b01, 64'h0000_0000_00A0_0010);
    issue(2'b10, link_of(K1, 52'hA0_0010));
    chk("R3 match", {63'b0, res_viol}, 64'd0);
    issue(2'b01, 64'h0000_0000_00A0_0010);
    issue(2'b10, link_of(K1, 52'hA0_0020));
    chk("R3 mismatch", {63'b0, res_viol}, 64'd1);
  endtask

  task automatic t_tag_bad();
    do_reset(); load_key(K1);
    issue(2'b01, 64'h0000_0000_0B00_0040);
    issue(2'b10, link_of(K1, 52'hB00_0040) ^ 64'h0010_0000_0000_0000);
    chk("R4 bad tag", {63'b0, res_viol}, 64'd1);
  endtask

  task automatic t_underflow();
    do_reset(); load_key(K1);
    issue(2'b10, link_of(K1, 52'h300));
    chk("R5 underflow", {63'b0, res_viol}, 64'd1);
  endtask

  task automatic t_overflow();
    do_reset(); load_key(K1);
    for (int i = 0; i < 17; i++) issue(2'b01, 64'h0000_0000_0001_0000 + 64'(i * 4));
    for (int i = 16; i >= 1; i--) begin
      issue(2'b10, link_of(K1, 52'h1_0000 + 52'(i * 4)));
      chk("R6 lifo", {63'b0, res_viol}, 64'd0);
    end
    issue(2'b10, link_of(K1, 52'h1_0000));
    chk("R6 oldest dropped", {63'b0, res_viol}, 64'd1);
  endtask

  task automatic t_base_call();
    do_reset(); load_key(K1);
    issue(2'b01, 64'h0000_0000_0000_5000);
    issue(2'b11, 64'h0000_0000_0000_6000);
    chk("R7 tagged", res_link, link_of(K1, 52'h6000));
    issue(2'b10, link_of(K1, 52'h5000));
    chk("R7 no push", {63'b0, res_viol}, 64'd0);
  endtask

  task automatic t_plain_jump();
    do_reset(); load_key(K1);
    issue(2'b01, 64'h0000_0000_0000_7000);
    issue(2'b00, 64'hDEAD_0000_0000_7777);
    chk("R8 link", res_link, 64'hDEAD_0000_0000_7777);
    chk("R8 viol", {63'b0, res_viol}, 64'd0);
    issue(2'b10, link_of(K1, 52'h7000));
    chk("R8 stack kept", {63'b0, res_viol}, 64'd0);
  endtask

  task automatic t_guard_off();
    do_reset(); load_key(K1);
    guard_en = 1'b0;
    issue(2'b01, 64'hABC0_0000_0000_8000);
    chk("R2 link", res_link, 64'hABC0_0000_0000_8000);
    issue(2'b10, 64'h1234_0000_0000_9999);
    chk("R2 viol", {63'b0, res_viol}, 64'd0);
    guard_en = 1'b1;
    issue(2'b10, link_of(K1, 52'h8000));
    chk("R2 no push", {63'b0, res_viol}, 64'd1);
  endtask

  task automatic t_key_once();
    do_reset();
    @(negedge clk);
    key_load = 1'b1; key_value = K1;
    ev_valid = 1'b1; ev_kind = 2'b01; ev_addr = 64'h0000_0000_0000_A000;
    @(negedge clk);
    key_load = 1'b0; ev_valid = 1'b0;
    chk("R9 same cycle", res_link, link_of(64'd0, 52'hA000));
    load_key(K2);
    issue(2'b01, 64'h0000_0000_0000_B000);
    chk("R9 first key kept", res_link, link_of(K1, 52'hB000));
  endtask

  task automatic t_backpressure();
    logic [63:0] la;
    logic [63:0] lb;
    do_reset(); load_key(K1);
    la = link_of(K1, 52'hC000);
    lb = link_of(K1, 52'hD000);
    @(negedge clk);
    res_ready = 1'b0;
    ev_valid = 1'b1; ev_kind = 2'b01; ev_addr = 64'h0000_0000_0000_C000;
    @(negedge clk);
    ev_addr = 64'h0000_0000_0000_D000;
    for (int i = 0; i < 3; i++) begin
      chk("R10 ready low", {63'b0, ev_ready}, 64'd0);
      chk("R10 held", res_link, la);
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R10 next result", res_link, lb);
    issue(2'b10, lb);
    chk("R10 pop b", {63'b0, res_viol}, 64'd0);
    issue(2'b10, la);
    chk("R10 pop a", {63'b0, res_viol}, 64'd0);
    issue(2'b10, la);
    chk("R10 single push", {63'b0, res_viol}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_call_tag();
    t_return_match();
    t_tag_bad();
    t_underflow();
    t_overflow();
    t_base_call();
    t_plain_jump();
    t_guard_off();
    t_key_once();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule